// File: doc/BRIEF.md
# Receive Destination Address Filter

This block takes the 48-bit destination address of each received Ethernet frame and returns an accept or drop decision. It holds a small address table of up to eight station addresses. Separate policies govern unicast, multicast and broadcast traffic. The table is stored byte-sliced: each lane register carries one address byte for every entry at once, so one register write updates the same byte position across the whole table. A per-entry mask selects which table slots take part in matching.

The surrounding port logic writes the lane registers, the mask and a small policy register through a plain write port. It then presents one destination address per cycle with a strobe. The decision comes out two clock cycles later with its own strobe. Lookups are served only while the port's packet enable input is high. Software is expected to lower that enable while it rewrites the filter and to restore it afterwards.

Top module: `rx_addr_filter`

## Requirements
- R1: After reset `dec_valid` is low, every mask bit is 0 and the policy register is 0. In that state unicast frames are accepted, and multicast and broadcast frames are dropped.
- R2: A request sampled with `req_valid` and `port_en` both high produces exactly one `dec_valid` pulse two rising edges later. `dec_accept` is meaningful only while `dec_valid` is high.
- R3: A request sampled while `port_en` is low is ignored. No `dec_valid` pulse follows it.
- R4: Write selects 0 to 5 address the lane registers. Lane b holds address byte b for all entries, and entry k sits in bits 8k+7:8k. Byte 0 is the first byte on the wire, `req_dst[47:40]`. An entry matches only when all six bytes are equal.
- R5: Select 6 writes the entry mask, with bit k for entry k. An entry whose mask bit is 0 never matches, whatever it holds.
- R6: Select 7 writes the policy register. Bit 0 is strict unicast mode. When it is 1, a unicast frame is accepted only on a table match. When it is 0, every unicast frame is accepted.
- R7: An address whose `req_dst[40]` is 1 (and which is not all ones) is multicast. Policy bits 2:1 decide it as follows: 0 accepts only on a table match, 1 drops all, 2 accepts all, and 3 drops all.
- R8: The all-ones address is broadcast and is classified before the multicast test. Policy bit 3 set accepts it regardless of the table. Bit 3 clear drops it, even if the table holds it.
- R9: A table, mask or policy write sampled on the same edge as a request, or while that request is in flight, does not change that request's decision. The next request uses the new contents.
- R10: Requests on consecutive cycles each receive their own decision on consecutive cycles, in order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 3 | Register select: 0-5 lanes, 6 mask, 7 policy |
| cfg_wdata | input | 64 | Write data |
| port_en | input | 1 | Port packet enable; lookups only while high |
| req_valid | input | 1 | Destination address valid |
| req_dst | input | 48 | Destination address, first byte in bits 47:40 |
| dec_valid | output | 1 | Decision valid |
| dec_accept | output | 1 | 1 accept, 0 drop |

## Verification
The bench builds the block with its default eight entries and six address bytes. This gives the full 64-bit lane layout, so an address placed in entry 7 exercises the top byte of every lane. Random tables that mix unicast and multicast entries, combined with random policies and masks, reach every class-by-mode combination. Lookups are drawn half from table contents, so hits occur often. Directed cases cover the same-edge write race, back-to-back requests, broadcast held in the table, and requests made with the port disabled.

// File: rtl/rx_addr_filter.sv
module rx_addr_filter #(
  parameter int ENTRIES    = 8,
  parameter int ADDR_BYTES = 6,
  localparam int REG_W     = 8 * ENTRIES,
  localparam int ADDR_W    = 8 * ADDR_BYTES,
  localparam int SEL_W     = $clog2(ADDR_BYTES + 2)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [SEL_W-1:0]  cfg_sel,
  input  logic [REG_W-1:0]  cfg_wdata,
  input  logic              port_en,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_dst,
  output logic              dec_valid,
  output logic              dec_accept
);

  localparam int SEL_MASK = ADDR_BYTES;
  localparam int SEL_CTRL = ADDR_BYTES + 1;

  logic [REG_W-1:0]   lane [ADDR_BYTES];
  logic [ENTRIES-1:0] ent_on;
  logic               strict_uc;
  logic [1:0]         mc_mode;
  logic               bc_en;

  logic [ENTRIES-1:0] hit_vec;
  logic               is_bc, is_mc;

  logic               s1_valid, s1_hit, s1_bc, s1_mc, s1_strict, s1_bcen;
  logic [1:0]         s1_mcmode;
  logic               verdict;

  // table and policy storage
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int b = 0; b < ADDR_BYTES; b++) lane[b] <= '0;
      ent_on    <= '0;
      strict_uc <= 1'b0;
      mc_mode   <= 2'd0;
      bc_en     <= 1'b0;
    end else if (cfg_we) begin
      for (int b = 0; b < ADDR_BYTES; b++)
        if (int'(cfg_sel) == b) lane[b] <= cfg_wdata;
      if (int'(cfg_sel) == SEL_MASK) ent_on <= cfg_wdata[ENTRIES-1:0];
      if (int'(cfg_sel) == SEL_CTRL) begin
        strict_uc <= cfg_wdata[0];
        mc_mode   <= cfg_wdata[2:1];
        bc_en     <= cfg_wdata[3];
      end
    end
  end

  // per-entry comparators
  for (genvar k = 0; k < ENTRIES; k++) begin : g_ent
    logic [ADDR_BYTES-1:0] byte_eq;
    for (genvar b = 0; b < ADDR_BYTES; b++) begin : g_byte
      assign byte_eq[b] = lane[b][8*k +: 8] == req_dst[ADDR_W-1-8*b -: 8];
    end
    assign hit_vec[k] = ent_on[k] & (&byte_eq);
  end

  assign is_bc = &req_dst;
  assign is_mc = req_dst[ADDR_W-8] & ~is_bc;

  // stage 1: capture match and policy
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_valid  <= 1'b0;
      s1_hit    <= 1'b0;
      s1_bc     <= 1'b0;
      s1_mc     <= 1'b0;
      s1_strict <= 1'b0;
      s1_bcen   <= 1'b0;
      s1_mcmode <= 2'd0;
    end else begin
      s1_valid <= req_valid & port_en;
      if (req_valid & port_en) begin
        s1_hit    <= |hit_vec;
        s1_bc     <= is_bc;
        s1_mc     <= is_mc;
        s1_strict <= strict_uc;
        s1_bcen   <= bc_en;
        s1_mcmode <= mc_mode;
      end
    end
  end

  always_comb begin
    if (s1_bc)
      verdict = s1_bcen;
    else if (s1_mc)
      case (s1_mcmode)
        2'd0:    verdict = s1_hit;
        2'd2:    verdict = 1'b1;
        default: verdict = 1'b0;
      endcase
    else
      verdict = ~s1_strict | s1_hit;
  end

  // stage 2: decision
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dec_valid  <= 1'b0;
      dec_accept <= 1'b0;
    end else begin
      dec_valid  <= s1_valid;
      dec_accept <= s1_valid & verdict;
    end
  end

  assert_off_ignored_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !port_en |=> !s1_valid);

  assert_accept_qualified_R2: assert property (@(posedge clk) disable iff (!rst_n)
    dec_accept |-> dec_valid);

  assert_bcast_pass_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (s1_valid && s1_bc && s1_bcen) |=> dec_accept);

  assert_mc_reject_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (s1_valid && s1_mc && s1_mcmode[0]) |=> !dec_accept);

  assert_uc_open_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (s1_valid && !s1_bc && !s1_mc && !s1_strict) |=> dec_accept);

endmodule

// File: tb/rx_addr_filter_bench.sv
module rx_addr_filter_bench;
  localparam int ENT = 8;
  localparam int NB  = 6;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_sel = '0;
  logic [63:0] cfg_wdata = '0;
  logic        port_en = 1'b0;
  logic        req_valid = 1'b0;
  logic [47:0] req_dst = '0;
  logic        dec_valid, dec_accept;

  int total = 0;
  int bad = 0;

  logic [63:0] sh_lane [NB];
  logic [7:0]  sh_mask;
  logic [3:0]  sh_ctrl;

  always #2 clk = ~clk;

  rx_addr_filter u_rx_addr_filter (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .port_en(port_en), .req_valid(req_valid),
    .req_dst(req_dst), .dec_valid(dec_valid), .dec_accept(dec_accept)
  );

  function automatic logic [47:0] entry_addr(int k);
    logic [47:0] a;
    for (int b = 0; b < NB; b++) a[47-8*b -: 8] = sh_lane[b][8*k +: 8];
    return a;
  endfunction

  function automatic logic expect_accept(logic [47:0] a);
    logic hit = 1'b0;
    for (int k = 0; k < ENT; k++)
      if (sh_mask[k] && entry_addr(k) == a) hit = 1'b1;
    if (a == 48'hFFFF_FFFF_FFFF) return sh_ctrl[3];
    if (a[40]) begin
      case (sh_ctrl[2:1])
        2'd0: return hit;
        2'd2: return 1'b1;
        default: return 1'b0;
      endcase
    end
    return !sh_ctrl[0] || hit;
  endfunction

  task automatic check(string req, logic act, logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0b expected=%0b", req, act, exp);
    end
  endtask

  task automatic wr(int sel, logic [63:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = 3'(sel); cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
    if (sel < NB) sh_lane[sel] = d;
    else if (sel == NB) sh_mask = d[7:0];
    else sh_ctrl = d[3:0];
  endtask

  task automatic put_entry(int k, logic [47:0] a);
    for (int b = 0; b < NB; b++) begin
      logic [63:0] v = sh_lane[b];
      v[8*k +: 8] = a[47-8*b -: 8];
      wr(b, v);
    end
  endtask

  task automatic lookup(string req, logic [47:0] a);
    logic e = expect_accept(a);
    @(negedge clk);
    req_valid = 1'b1; req_dst = a;
    @(negedge clk);
    req_valid = 1'b0;
    @(negedge clk);
    check(req, dec_valid, 1'b1);
    check(req, dec_accept, e);
  endtask

  function automatic logic [47:0] rnd_addr();
    logic [63:0] t = {$urandom(), $urandom()};
    return t[47:0];
  endfunction

  initial begin
    #(4ns * 200000);
    bad++; total++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [47:0] ua, ma, bc;
    void'($urandom(32'd2024));
    for (int b = 0; b < NB; b++) sh_lane[b] = '0;
    sh_mask = '0; sh_ctrl = '0;
    bc = '1;
    ua = 48'h02_11_22_33_44_56;
    ma = 48'h01_00_5E_10_20_30;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    port_en = 1'b1;
    @(negedge clk);
    check("R1 reset dec_valid", dec_valid, 1'b0);
    lookup("R1 reset unicast", ua);
    check("R1 model uc", dec_accept, 1'b1);
    lookup("R1 reset multicast", ma);
    lookup("R1 reset broadcast", bc);

    // R3: port disabled
    port_en = 1'b0;
    @(negedge clk); req_valid = 1'b1; req_dst = ua;
    @(negedge clk); req_valid = 1'b0;
    check("R3 no decision 1", dec_valid, 1'b0);
    @(negedge clk);
    check("R3 no decision 2", dec_valid, 1'b0);
    @(negedge clk);
    check("R3 no decision 3", dec_valid, 1'b0);
    port_en = 1'b1;

    // R4 R5 R6: strict unicast with entry 7
    wr(7, 64'h1);
    put_entry(7, ua);
    lookup("R5 masked entry no hit", ua);
    wr(6, 64'h80);
    lookup("R4 entry7 hit", ua);
    lookup("R4 one byte differs", ua ^ 48'h00_00_00_00_00_01);
    lookup("R4 first byte differs", ua ^ 48'h04_00_00_00_00_00);
    lookup("R6 strict miss", 48'h02_AA_BB_CC_DD_EE);
    wr(7, 64'h0);
    lookup("R6 open accepts", 48'h02_AA_BB_CC_DD_EE);

    // R7 multicast modes
    put_entry(2, ma);
    wr(6, 64'h84);
    for (int m = 0; m < 4; m++) begin
      wr(7, 64'(m << 1));
      lookup($sformatf("R7 mode%0d hit addr", m), ma);
      lookup($sformatf("R7 mode%0d miss addr", m), ma ^ 48'h00_00_00_00_00_F0);
    end

    // R8 broadcast, even when held in the table
    put_entry(0, bc);
    wr(6, 64'h85);
    wr(7, 64'h5);
    lookup("R8 bcast off in table", bc);
    wr(7, 64'h8);
    lookup("R8 bcast on", bc);

    // R9: same-edge write and in-flight policy write
    wr(7, 64'h1);
    begin
      logic [63:0] nv = sh_lane[5];
      nv[63:56] = ~nv[63:56];
      @(negedge clk);
      req_valid = 1'b1; req_dst = ua;
      cfg_we = 1'b1; cfg_sel = 3'd5; cfg_wdata = nv;
      @(negedge clk);
      req_valid = 1'b0;
      cfg_we = 1'b1; cfg_sel = 3'd7; cfg_wdata = 64'h0;
      @(negedge clk);
      cfg_we = 1'b0;
      check("R9 old table used valid", dec_valid, 1'b1);
      check("R9 old table used", dec_accept, 1'b1);
      sh_lane[5] = nv;
      sh_ctrl = 4'h0;
      wr(7, 64'h1);
      lookup("R9 new table next", ua);
    end

    // R10: back-to-back
    begin
      logic [47:0] q [3];
      logic e [3];
      q[0] = ua; q[1] = ma; q[2] = bc;
      wr(7, 64'h9);
      for (int i = 0; i < 3; i++) e[i] = expect_accept(q[i]);
      @(negedge clk);
      for (int i = 0; i < 3; i++) begin
        req_valid = 1'b1; req_dst = q[i];
        @(negedge clk);
        if (i >= 1) begin
          check("R10 pipelined valid", dec_valid, 1'b1);
          check("R10 pipelined accept", dec_accept, e[i-1]);
        end
      end
      req_valid = 1'b0;
      @(negedge clk);
      check("R10 last valid", dec_valid, 1'b1);
      check("R10 last accept", dec_accept, e[2]);
      @(negedge clk);
      check("R2 single pulse", dec_valid, 1'b0);
    end

    // random
    for (int r = 0; r < 40; r++) begin
      for (int k = 0; k < ENT; k++) begin
        logic [47:0] a = rnd_addr();
        if ($urandom_range(0, 2) == 0) a[40] = 1'b1;
        put_entry(k, a);
      end
      wr(6, 64'($urandom_range(0, 255)));
      for (int j = 0; j < 8; j++) begin
        logic [47:0] a;
        if (j == 4) wr(7, 64'($urandom_range(0, 15)));
        case ($urandom_range(0, 3))
          0, 1: a = entry_addr($urandom_range(0, ENT-1));
          2: a = rnd_addr();
          default: a = bc;
        endcase
        lookup("R6 R7 R8 random", a);
      end
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule